// File: doc/BRIEF.md
# Addressed Serial Port Latch Receiver

This block is the receiving end of a three-wire synchronous control link made of a bus clock, a data line and a select line. It samples all three lines with the faster system clock and waits for both the bus clock and select to be high, which opens a frame. While select stays high, each rising bus-clock edge samples one data bit. The first eight bits form an address, received LSB first, and are compared with a module address set on strap inputs.

When the address matches, the next sixteen bits are shifted in. The first of these bits drives port 1 (`port_q[0]`). The received bits reach the outputs only when the bus clock is held high while select drops low and rises again. Dropping both lines low ends the frame. If the address does not match, if the frame is cut short, or if the select toggle happens without the clock held high, the outputs keep their previous value.

Top module: `sdl_port_latch`

## Requirements
- R1: While reset is asserted and after it is released, `port_q` is all zeros until the first committed frame.
- R2: A frame opens when the synchronised bus clock and select are both high. After that, one data bit is taken on each rising bus-clock edge while select is high.
- R3: The first 8 bits of a frame are the address, received LSB first. If they differ from `strap_addr` in any bit, no data is captured and `port_q` keeps its value.
- R4: After a matching address, the next 16 bits are captured. Bit k of the data (k = 0 first on the wire) appears on `port_q[k]`.
- R5: `port_q` changes only when select falls and then rises while the bus clock stays high, after a matching frame of exactly 24 or more bits.
- R6: A select strobe that arrives before all 16 data bits have been received leaves `port_q` unchanged.
- R7: Driving both lines low ends the frame and clears the bit count. So does a rising bus-clock edge while select is low. The next frame then counts from bit zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| strap_addr | input | 8 | Module address strap |
| bus_clk | input | 1 | Serial link clock (asynchronous) |
| bus_dat | input | 1 | Serial link data (asynchronous) |
| bus_sel | input | 1 | Serial link select / latch strobe (asynchronous) |
| port_q | output | 16 | Latched port outputs |

## Verification
The bench sends matching frames with asymmetric patterns (0xA5C3 and a lone 0x0001) to expose bit reversal or an offset in the data field. All-ones and all-zeros frames show that every port can be both set and cleared. Addresses that differ from the strap only in the MSB or only in the LSB show that all eight address bits are compared. A frame cut short after ten data bits shows that a strobe on a partial frame is refused. A partial frame followed by stray clock pulses with select low and then a full frame shows that the count restarts at bit zero.

// File: rtl/sdl_port_latch.sv
module sdl_port_latch #(
  parameter int AW = 8,
  parameter int NP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_addr,
  input  logic          bus_clk,
  input  logic          bus_dat,
  input  logic          bus_sel,
  output logic [NP-1:0] port_q
);
  localparam int NB = AW + NP;
  localparam int CW = $clog2(NB + 1);
  localparam logic [CW-1:0] NB_C = CW'(NB);
  localparam logic [CW-1:0] AW_C = CW'(AW);

  logic [2:0] ck_p, sl_p;
  logic [1:0] dt_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_p <= '0;
      sl_p <= '0;
      dt_p <= '0;
    end else begin
      ck_p <= {ck_p[1:0], bus_clk};
      sl_p <= {sl_p[1:0], bus_sel};
      dt_p <= {dt_p[0], bus_dat};
    end

  wire ck_s    = ck_p[1];
  wire sl_s    = sl_p[1];
  wire dt_s    = dt_p[1];
  wire ck_rise = ck_s & ~ck_p[2];
  wire sl_fall = ~sl_s & sl_p[2];
  wire sl_rise = sl_s & ~sl_p[2];

  logic          active, arm, addr_ok;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_sr;
  logic [NP-1:0] dat_sr;

  wire commit = active && arm && sl_rise && ck_s && addr_ok && (cnt == NB_C);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active  <= 1'b0;
      arm     <= 1'b0;
      addr_ok <= 1'b0;
      cnt     <= '0;
      addr_sr <= '0;
      dat_sr  <= '0;
    end else if (!ck_s && !sl_s) begin
      active  <= 1'b0;
      arm     <= 1'b0;
      addr_ok <= 1'b0;
      cnt     <= '0;
    end else if (!active) begin
      if (ck_s && sl_s) begin
        active  <= 1'b1;
        arm     <= 1'b0;
        addr_ok <= 1'b0;
        cnt     <= '0;
      end
    end else if (ck_rise && !sl_s) begin
      active  <= 1'b0;
      arm     <= 1'b0;
      addr_ok <= 1'b0;
      cnt     <= '0;
    end else begin
      if (ck_rise && sl_s) begin
        if (cnt < NB_C) cnt <= cnt + 1'b1;
        if (cnt < AW_C) addr_sr <= {dt_s, addr_sr[AW-1:1]};
        if (cnt == AW_C - 1'b1) addr_ok <= ({dt_s, addr_sr[AW-1:1]} == strap_addr);
        if (cnt >= AW_C && cnt < NB_C && addr_ok) dat_sr <= {dt_s, dat_sr[NP-1:1]};
      end
      if (sl_fall && ck_s) arm <= 1'b1;
      else if (sl_rise) arm <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) port_q <= '0;
    else if (commit) port_q <= dat_sr;

endmodule

// File: rtl/sdl_port_latch_chk.sv
module sdl_port_latch_chk #(
  parameter int NP = 16,
  parameter int CW = 5,
  parameter int NB = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] port_q,
  input logic          ck_s,
  input logic          sl_s,
  input logic          sl_rise,
  input logic          arm,
  input logic          addr_ok,
  input logic [CW-1:0] cnt
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> port_q == '0);

  a_r5_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q != $past(port_q)) |-> $past(sl_rise && ck_s && arm));

  a_r3_change_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q != $past(port_q)) |-> $past(addr_ok));

  a_r6_change_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q != $past(port_q)) |-> ($past(cnt) == CW'(NB)));

  a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_s && !sl_s) |=> (cnt == '0));
endmodule

bind sdl_port_latch sdl_port_latch_chk #(.NP(NP), .CW(CW), .NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .port_q(port_q), .ck_s(ck_s), .sl_s(sl_s),
  .sl_rise(sl_rise), .arm(arm), .addr_ok(addr_ok), .cnt(cnt)
);

// File: tb/sdl_port_latch_tb.sv
module sdl_port_latch_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] strap_addr = 8'h2D;
  logic bus_clk = 1'b0, bus_dat = 1'b0, bus_sel = 1'b0;
  logic [15:0] port_q;
  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  event chk_ev;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdl_port_latch dut_i (.clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .bus_clk(bus_clk), .bus_dat(bus_dat), .bus_sel(bus_sel), .port_q(port_q));

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    bus_clk = 1'b0; bus_dat = b; wait_sys(4);
    bus_clk = 1'b1; wait_sys(4);
  endtask

  task automatic open_frame();
    bus_sel = 1'b1; bus_clk = 1'b1; wait_sys(8);
  endtask

  task automatic close_frame(input bit strobe);
    if (strobe) begin
      bus_sel = 1'b0; wait_sys(6);
      bus_sel = 1'b1; wait_sys(6);
    end
    bus_clk = 1'b0; bus_sel = 1'b0; wait_sys(8);
  endtask

  task automatic frame(input logic [7:0] a, input logic [15:0] d, input int ndat);
    open_frame();
    for (int i = 0; i < 8; i++) send_bit(a[i]);
    for (int i = 0; i < ndat; i++) send_bit(d[i]);
    close_frame(1'b1);
  endtask

  task automatic expect_q(input logic [15:0] e, input string tag);
    wait_sys(4);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> chk_ev;
    wait_sys(1);
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (port_q !== e) begin
          n_fail++;
          $display("FAIL %s: port_q=%h expected %h", t, port_q, e);
        end
      end
    end
  end

  initial begin
    wait_sys(3);
    n_run++;
    if (port_q !== 16'h0) begin n_fail++; $display("FAIL R1 in reset: port_q=%h expected 0000", port_q); end
    rst_n = 1'b1;
    wait_sys(5);
    expect_q(16'h0000, "R1 after reset");

    frame(8'h2D, 16'hA5C3, 16);
    expect_q(16'hA5C3, "R2/R4 matching frame");
    frame(8'h2D, 16'h0001, 16);
    expect_q(16'h0001, "R4 first bit to port 1");
    frame(8'hAD, 16'hFFFF, 16);
    expect_q(16'h0001, "R3 MSB address mismatch");
    frame(8'h2C, 16'hFFFF, 16);
    expect_q(16'h0001, "R3 LSB address mismatch");
    frame(8'h2D, 16'hFFFF, 16);
    expect_q(16'hFFFF, "R4 all ones");
    frame(8'h2D, 16'h0000, 10);
    expect_q(16'hFFFF, "R6 short frame");
    frame(8'h2D, 16'h0000, 16);
    expect_q(16'h0000, "R4 all zeros");

    open_frame();
    for (int i = 0; i < 8; i++) send_bit(strap_addr[i]);
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    bus_clk = 1'b0; wait_sys(6);
    bus_sel = 1'b0; wait_sys(6);
    bus_sel = 1'b1; wait_sys(6);
    bus_sel = 1'b0; wait_sys(8);
    expect_q(16'h0000, "R5 strobe with clock low");

    open_frame();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_sel = 1'b0;
    for (int i = 0; i < 3; i++) begin
      bus_clk = 1'b0; wait_sys(4);
      bus_clk = 1'b1; wait_sys(4);
    end
    bus_clk = 1'b0; wait_sys(6);
    frame(8'h2D, 16'h5A3C, 16);
    expect_q(16'h5A3C, "R7 recount after stray clocks");

    frame(8'h2D, 16'h8000, 16);
    expect_q(16'h8000, "R4 last bit to port 16");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    wait_sys(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule